// File: doc/BRIEF.md
# Shadow Register Reload Controller

This block keeps a bank of per-sub-unit configuration words for a display pipeline. Each sub-unit has two copies of its word. A host register interface writes the staged copy. The live copy is what the sub-unit's datapath would consume. Staged values move into the live copies only at a frame boundary, and only after the host has asked for it by writing the engine-enable register. A host can therefore prepare a full set of changes over several cycles without the display ever seeing a half-updated configuration.

Two 32-bit reload-disable words act as a per-sub-unit freeze mask. A sub-unit whose bit is set keeps its live word through a commit. Sub-units fall into four groups: read-DMA, clip, overlay and colour-transform. Each group starts at a fixed base index, and a channel inside a group is found by adding its channel number to that base. A separate read port takes a group and a channel and returns the live word, so the state the datapath would see can be checked.

Top module: `shadow_reload_ctrl`

## Requirements
- R1: After reset, both reload-disable words read 0xFFFFFFFF, the engine-enable register reads 0, and every staged and live word is 0.
- R2: A host write to address n (0 to NUM_UNITS-1) updates the staged word of sub-unit n. That word reads back at address n from the next cycle. The write does not change the live word.
- R3: A write to address 0x42 with bit 0 set enables the engine and arms a flush. A write there with bit 0 clear disables the engine and cancels any armed flush. The register reads back as bit 0.
- R4: On a frame_end pulse while a flush is armed, every sub-unit whose disable bit is 0 copies its staged word into its live word. The flush is then disarmed, unless a new flush is written in that same cycle.
- R5: The disable bit of sub-unit n is bit n mod 32 of word n/32. Word 0 is at address 0x40 and word 1 at address 0x41. A sub-unit whose bit is 1 keeps its live word through a commit. A commit uses the disable words as they stood before any write made in the same cycle.
- R6: A frame_end pulse with no armed flush leaves every live word unchanged.
- R7: If a flush is written in the same cycle as a frame_end pulse and no flush was armed before, nothing commits in that cycle. The commit happens at the following frame_end.
- R8: The live read port returns the live word of sub-unit base(group) + channel. The bases are 0 for group 0 (read-DMA), 20 for group 1 (clip), 40 for group 2 (overlay) and 52 for group 3 (colour-transform). The port returns 0 when that sum is NUM_UNITS or more.
- R9: If a staged word is written in the same cycle as a commit, the live word takes the staged value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_end | input | 1 | One-cycle pulse at the end of each frame |
| host_we | input | 1 | Host write strobe |
| host_waddr | input | AW | Host write address |
| host_wdata | input | 32 | Host write data |
| host_raddr | input | AW | Host read address |
| host_rdata | output | 32 | Host read data: staged word, disable word or enable register |
| live_grp | input | 2 | Group select for the live read port |
| live_ch | input | CHW | Channel inside the selected group |
| live_rdata | output | DW | Live word of the selected sub-unit |

## Verification
The bench targets the boundaries of the disable-bit index. Sub-unit 36 and sub-unit 37 sit in word 1, and an index that is off by one word or one bit would let a frozen sub-unit update or keep a released one frozen. It also covers a flush written in the same cycle as frame_end, where a design that commits at once would expose the configuration one frame early. It covers a staged write landing in the commit cycle, where forwarding would publish the new value instead of the old one. Finally, it checks that a flush cancelled before the frame ends never commits, and it runs random traffic against a cycle model, including group and channel sums past the last sub-unit.

// File: rtl/shadow_reload_ctrl.sv
module shadow_reload_ctrl #(
  parameter int NUM_UNITS  = 64,
  parameter int DW         = 32,
  parameter int AW         = 8,
  parameter int CHW        = 5,
  parameter int RDMA_BASE  = 0,
  parameter int CLIP_BASE  = 20,
  parameter int OVLY_BASE  = 40,
  parameter int CTRAN_BASE = 52,
  parameter logic [AW-1:0] ADDR_DIS0 = 8'h40,
  parameter logic [AW-1:0] ADDR_DIS1 = 8'h41,
  parameter logic [AW-1:0] ADDR_EN   = 8'h42
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           frame_end,
  input  logic           host_we,
  input  logic [AW-1:0]  host_waddr,
  input  logic [31:0]    host_wdata,
  input  logic [AW-1:0]  host_raddr,
  output logic [31:0]    host_rdata,
  input  logic [1:0]     live_grp,
  input  logic [CHW-1:0] live_ch,
  output logic [DW-1:0]  live_rdata
);
  localparam int UIW = $clog2(NUM_UNITS);

  logic [NUM_UNITS-1:0][DW-1:0] staged_q, live_q;
  logic [1:0][31:0] dis_q;
  logic [63:0] dis_vec;
  logic eng_q, armed_q;
  logic commit, en_wr, flush_wr;
  logic [7:0] lidx;

  assign dis_vec  = {dis_q[1], dis_q[0]};
  assign en_wr    = host_we && (host_waddr == ADDR_EN);
  assign flush_wr = en_wr && host_wdata[0];
  assign commit   = frame_end && armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eng_q   <= 1'b0;
      armed_q <= 1'b0;
    end else if (en_wr) begin
      eng_q   <= host_wdata[0];
      armed_q <= host_wdata[0];
    end else if (commit) begin
      armed_q <= 1'b0;
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_dis
    always_ff @(posedge clk) begin
      if (!rst_n)
        dis_q[w] <= '1;
      else if (host_we && (host_waddr == (w == 0 ? ADDR_DIS0 : ADDR_DIS1)))
        dis_q[w] <= host_wdata;
    end
  end

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n)
        staged_q[u] <= '0;
      else if (host_we && (host_waddr == AW'(u)))
        staged_q[u] <= host_wdata[DW-1:0];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        live_q[u] <= '0;
      else if (commit && !dis_vec[u])
        live_q[u] <= staged_q[u];
    end

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_vec[u] |=> $stable(live_q[u]));
    // R4
    copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && !dis_vec[u]) |=> (live_q[u] == $past(staged_q[u])));
  end

  always_comb begin
    if (int'(host_raddr) < NUM_UNITS)
      host_rdata = 32'(staged_q[host_raddr[UIW-1:0]]);
    else if (host_raddr == ADDR_DIS0)
      host_rdata = dis_q[0];
    else if (host_raddr == ADDR_DIS1)
      host_rdata = dis_q[1];
    else if (host_raddr == ADDR_EN)
      host_rdata = {31'b0, eng_q};
    else
      host_rdata = '0;
  end

  always_comb begin
    case (live_grp)
      2'd0:    lidx = 8'(RDMA_BASE)  + 8'(live_ch);
      2'd1:    lidx = 8'(CLIP_BASE)  + 8'(live_ch);
      2'd2:    lidx = 8'(OVLY_BASE)  + 8'(live_ch);
      default: lidx = 8'(CTRAN_BASE) + 8'(live_ch);
    endcase
    if (int'(lidx) < NUM_UNITS)
      live_rdata = live_q[lidx[UIW-1:0]];
    else
      live_rdata = '0;
  end

  // R3
  flush_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |=> armed_q);
  // R4
  commit_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !en_wr) |=> !armed_q);
  // R6
  no_commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(live_q));
  // R7
  deferred_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !armed_q && flush_wr) |=> (armed_q && $stable(live_q)));
endmodule

// File: tb/shadow_reload_ctrl_tb.sv
module shadow_reload_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NU = 64;

  logic clk = 0, rst_n = 0, frame_end = 0, host_we = 0;
  logic [7:0] host_waddr = 0, host_raddr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic [1:0] live_grp = 0;
  logic [4:0] live_ch = 0;
  logic [31:0] live_rdata;

  int checks = 0, errors = 0;
  logic [31:0] m_staged [NU];
  logic [31:0] m_live [NU];
  logic [31:0] m_dis [2];
  logic m_eng, m_armed;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_reload_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .frame_end(frame_end),
    .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
    .host_raddr(host_raddr), .host_rdata(host_rdata),
    .live_grp(live_grp), .live_ch(live_ch), .live_rdata(live_rdata));

  function automatic int unit_of(input logic [1:0] g, input logic [4:0] ch);
    int b;
    case (g)
      2'd0: b = 0;
      2'd1: b = 20;
      2'd2: b = 40;
      default: b = 52;
    endcase
    return b + int'(ch);
  endfunction

  function automatic logic mdis(input int n);
    return m_dis[n / 32][n % 32];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d, input logic fe);
    logic c;
    @(negedge clk);
    host_we = we; host_waddr = a; host_wdata = d; frame_end = fe;
    @(posedge clk);
    #1;
    c = fe && m_armed;
    if (c)
      for (int u = 0; u < NU; u++)
        if (!mdis(u)) m_live[u] = m_staged[u];
    if (we && a == 8'h42) begin
      m_eng = d[0]; m_armed = d[0];
    end else if (c) m_armed = 1'b0;
    if (we) begin
      if (int'(a) < NU) m_staged[a] = d;
      else if (a == 8'h40) m_dis[0] = d;
      else if (a == 8'h41) m_dis[1] = d;
    end
    host_we = 0; frame_end = 0;
  endtask

  task automatic rd_host(input logic [7:0] a, output logic [31:0] v);
    host_raddr = a; #1; v = host_rdata;
  endtask

  task automatic rd_live(input logic [1:0] g, input logic [4:0] ch, output logic [31:0] v);
    live_grp = g; live_ch = ch; #1; v = live_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    for (int u = 0; u < NU; u++) begin m_staged[u] = 0; m_live[u] = 0; end
    m_dis[0] = '1; m_dis[1] = '1; m_eng = 0; m_armed = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;

    // R1 reset state
    rd_host(8'h40, v); check("R1 dis0", v, 32'hFFFFFFFF);
    rd_host(8'h41, v); check("R1 dis1", v, 32'hFFFFFFFF);
    rd_host(8'h42, v); check("R1 enable", v, 0);
    rd_host(8'd5, v);  check("R1 staged", v, 0);
    rd_live(2'd0, 5'd0, v); check("R1 live", v, 0);

    // R2 staged write
    step(1, 8'd3, 32'hA5, 0);
    rd_host(8'd3, v); check("R2 staged readback", v, 32'hA5);
    rd_live(2'd0, 5'd3, v); check("R2 live untouched", v, 0);

    // R3/R4 flush then commit
    step(1, 8'h40, ~(32'h1 << 3), 0);
    step(1, 8'h42, 1, 0);
    rd_host(8'h42, v); check("R3 enable reads 1", v, 1);
    step(0, 0, 0, 1);
    rd_live(2'd0, 5'd3, v); check("R4 commit", v, 32'hA5);

    // R5 word 1 indexing: units 36 and 37
    step(1, 8'd36, 32'h36, 0);
    step(1, 8'd37, 32'h37, 0);
    step(1, 8'h40, 0, 0);
    step(1, 8'h42, 1, 0);
    step(0, 0, 0, 1);
    rd_live(2'd1, 5'd17, v); check("R5 frozen unit 37", v, 0);
    step(1, 8'h41, ~(32'h1 << 5), 0);
    step(1, 8'h42, 1, 0);
    step(0, 0, 0, 1);
    rd_live(2'd1, 5'd17, v); check("R5 released unit 37 (R8 group 1)", v, 32'h37);
    rd_live(2'd1, 5'd16, v); check("R5 unit 36 still frozen", v, 0);

    // R6 frame end without flush
    step(1, 8'd3, 32'h11, 0);
    step(0, 0, 0, 1);
    rd_live(2'd0, 5'd3, v); check("R6 no flush no change", v, 32'hA5);

    // R7 flush in same cycle as frame end
    step(1, 8'h42, 1, 1);
    rd_live(2'd0, 5'd3, v); check("R7 deferred", v, 32'hA5);
    step(0, 0, 0, 1);
    rd_live(2'd0, 5'd3, v); check("R7 next frame commit", v, 32'h11);

    // R3 cancel
    step(1, 8'd3, 32'h22, 0);
    step(1, 8'h42, 1, 0);
    step(1, 8'h42, 0, 0);
    step(0, 0, 0, 1);
    rd_live(2'd0, 5'd3, v); check("R3 cancelled flush", v, 32'h11);
    rd_host(8'h42, v); check("R3 enable reads 0", v, 0);

    // R9 staged write during commit
    step(1, 8'h42, 1, 0);
    step(1, 8'd3, 32'h33, 1);
    rd_live(2'd0, 5'd3, v); check("R9 old staged value", v, 32'h22);
    step(1, 8'h42, 1, 0);
    step(0, 0, 0, 1);
    rd_live(2'd0, 5'd3, v); check("R9 later commit", v, 32'h33);

    // random traffic against the model (R2 R4 R5 R8)
    for (int i = 0; i < 3000; i++) begin
      int r, ui;
      logic [7:0] a;
      logic [1:0] g;
      logic [4:0] ch;
      r = $urandom_range(0, 9);
      if (r < 7) a = 8'($urandom_range(0, NU - 1));
      else if (r == 7) a = 8'h40;
      else if (r == 8) a = 8'h41;
      else a = 8'h42;
      step($urandom_range(0, 1) == 1, a, $urandom, $urandom_range(0, 6) == 0);
      g = 2'($urandom_range(0, 3));
      ch = 5'($urandom_range(0, 31));
      ui = unit_of(g, ch);
      rd_live(g, ch, v);
      check("R8 random live", v, (ui < NU) ? m_live[ui] : 32'h0);
      a = 8'($urandom_range(0, 66));
      rd_host(a, v);
      if (int'(a) < NU) check("R2 random staged", v, m_staged[a]);
      else if (a == 8'h40) check("R5 random dis0", v, m_dis[0]);
      else if (a == 8'h41) check("R5 random dis1", v, m_dis[1]);
      else if (a == 8'h42) check("R3 random enable", v, {31'b0, m_eng});
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule